// File: doc/BRIEF.md
# Processor-Side Interrupt Acknowledge and Completion Registers

This block is the register interface that one processor core uses to talk to its interrupt controller. It holds the core's priority mask, a binary point value for each of the two interrupt groups, and an enable for each group. It also exposes a fixed control value. Its main job is to serve two operations on a 32-entry pending bitmap and a 32-entry active bitmap. An acknowledge read takes the lowest-numbered pending interrupt, returns its ID and marks it active. A completion write clears the active mark of a given ID.

The pending and active bitmaps live in this block. The neighbouring distributor logic changes them through four set/clear vectors, and it sees them through the `pend_q` and `act_q` outputs. Registers are reached with a 4-bit select, a read strobe and a write strobe, each one cycle wide, and 64-bit data. Read data comes back one cycle after the strobe, qualified by `rd_valid`.

A small state machine sequences the read response. It has two states. `ST_IDLE` means no response is being presented. `ST_DONE` means `rd_data` holds the result of the read accepted on the previous edge. The transition `IDLE_TO_DONE` is taken on a read strobe. `DONE_TO_DONE` is taken on a back-to-back read strobe. `DONE_TO_IDLE` is taken when no read strobe is present.

Top module: `cpuif_top`

## Requirements
- R1: A read of select 6 (acknowledge) while any pending bit is set returns the index of the lowest set pending bit in `rd_data` and sets that bit in the active bitmap. The pending bitmap is left unchanged. The side effect happens exactly once per read strobe.
- R2: A read of select 6 while no pending bit is set returns 1023 and leaves both bitmaps unchanged.
- R3: A write to select 7 (completion) with data below 32 clears active bit `wr_data[4:0]` and does not touch the pending bitmap. A write with data of 32 or more changes nothing and pulses `err`.
- R4: Select 0 is the priority mask. A write keeps `wr_data[7:0]`, and a read returns it zero-extended.
- R5: Select 1 is the group-0 binary point and select 2 is the group-1 binary point. Each keeps only `wr_data[2:0]`, reads back those three bits, and is changed only by a write to its own select.
- R6: Selects 3 and 4 are the group-0 and group-1 enables. A write loads bit 0 of the data, and a read returns the enable in bit 0 with all other bits zero.
- R7: Select 5 always reads 0x440: bit 6 set as the priority-mask hint flag, bits [10:8] = 4 as the priority-bits field, and bits [13:11] = 0 meaning 16-bit IDs. Writes to it change nothing and raise no error.
- R8: Selects 8 to 15, a write to select 6 and a read of select 7 are faults. A faulting read returns zero, a faulting write changes no state, and `err` is high for exactly the cycle after the strobe.
- R9: `rd_valid` is high in the cycle after each read strobe, with `rd_data` valid in that cycle, and low otherwise.
- R10: When a bitmap operation and external set/clear vectors arrive in the same cycle, they apply in a fixed order. External set is applied first, then external clear, and the acknowledge or completion is applied last. Acknowledge picks from the pending bitmap as it stood before that edge.
- R11: After reset, both bitmaps, the mask, both binary points, both enables, `rd_valid` and `err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 4 | Register select |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data, valid while rd_valid is high |
| rd_valid | output | 1 | Read response valid |
| err | output | 1 | Access fault pulse |
| ext_pend_set | input | 32 | Pending bits to set |
| ext_pend_clr | input | 32 | Pending bits to clear |
| ext_act_set | input | 32 | Active bits to set |
| ext_act_clr | input | 32 | Active bits to clear |
| pend_q | output | 32 | Pending bitmap |
| act_q | output | 32 | Active bitmap |

## Verification
The assertions assume that `rd_stb` and `wr_stb` are never high in the same cycle. They also assume that the caller leaves the external vectors at zero whenever a pending-stability property is meant to apply. The bench drives every access as a single-strobe cycle at the falling edge and drops all inputs at the next falling edge. It raises external vectors together with a strobe only in the precedence tests, where the affected properties carry matching guards. Sweeps cover every interrupt index for acknowledge and completion, all 256 mask values, and all binary point and enable encodings.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

    localparam int unsigned SEL_W   = 4;
    localparam int unsigned DATA_W  = 64;
    localparam logic [63:0] CTRL_VALUE = 64'h0000_0000_0000_0440;
    localparam int unsigned NONE_ID = 1023;

    typedef enum logic [3:0] {
        K_PMASK,
        K_BP0,
        K_BP1,
        K_GEN0,
        K_GEN1,
        K_CTRL,
        K_ACK,
        K_EOI,
        K_NONE
    } kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_DONE
    } rsp_st_e;

endpackage

// File: rtl/cpuif_decode.sv
module cpuif_decode
    import cpuif_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output kind_e            kind
);
    always_comb begin
        unique case (sel)
            4'd0:    kind = K_PMASK;
            4'd1:    kind = K_BP0;
            4'd2:    kind = K_BP1;
            4'd3:    kind = K_GEN0;
            4'd4:    kind = K_GEN1;
            4'd5:    kind = K_CTRL;
            4'd6:    kind = K_ACK;
            4'd7:    kind = K_EOI;
            default: kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/cpuif_pick.sv
module cpuif_pick #(
    parameter int unsigned N    = 32,
    localparam int unsigned IW  = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // lowest set bit wins: scan from the top so the last hit is the lowest
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
    assign found = |vec;
endmodule

// File: rtl/cpuif_bitmaps.sv
module cpuif_bitmaps #(
    parameter int unsigned N    = 32,
    localparam int unsigned IW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  ps,
    input  logic [N-1:0]  pc,
    input  logic [N-1:0]  as_in,
    input  logic [N-1:0]  ac_in,
    input  logic          ack_fire,
    input  logic [IW-1:0] ack_idx,
    input  logic          eoi_fire,
    input  logic [IW-1:0] eoi_idx,
    output logic [N-1:0]  pend,
    output logic [N-1:0]  act
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic p_nx, a_nx;
        always_comb begin
            p_nx = (pend[g] | ps[g]) & ~pc[g];
            a_nx = (act[g] | as_in[g]) & ~ac_in[g];
            if (ack_fire && ack_idx == IW'(g)) a_nx = 1'b1;
            if (eoi_fire && eoi_idx == IW'(g)) a_nx = 1'b0;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[g] <= 1'b0;
                act[g]  <= 1'b0;
            end else begin
                pend[g] <= p_nx;
                act[g]  <= a_nx;
            end
        end
    end
endmodule

// File: rtl/cpuif_top.sv
module cpuif_top
    import cpuif_pkg::*;
#(
    parameter int unsigned N_IRQ = 32,
    localparam int unsigned IW   = $clog2(N_IRQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              err,
    input  logic [N_IRQ-1:0]  ext_pend_set,
    input  logic [N_IRQ-1:0]  ext_pend_clr,
    input  logic [N_IRQ-1:0]  ext_act_set,
    input  logic [N_IRQ-1:0]  ext_act_clr,
    output logic [N_IRQ-1:0]  pend_q,
    output logic [N_IRQ-1:0]  act_q
);
    kind_e        kind;
    logic         pick_found;
    logic [IW-1:0] pick_idx;
    logic         ack_fire, eoi_fire, eoi_bad;
    logic [7:0]   pmask;
    logic [2:0]   bp0, bp1;
    logic         gen0, gen1;
    logic [DATA_W-1:0] rd_next;
    logic         err_next;
    rsp_st_e      st, st_nx;

    cpuif_decode i_dec (.sel(reg_sel), .kind(kind));

    cpuif_pick #(.N(N_IRQ)) i_pick (
        .vec(pend_q), .found(pick_found), .idx(pick_idx)
    );

    assign ack_fire = rd_stb && kind == K_ACK && pick_found;
    assign eoi_bad  = wr_data >= DATA_W'(N_IRQ);
    assign eoi_fire = wr_stb && kind == K_EOI && !eoi_bad;

    cpuif_bitmaps #(.N(N_IRQ)) i_bm (
        .clk(clk), .rst_n(rst_n),
        .ps(ext_pend_set), .pc(ext_pend_clr),
        .as_in(ext_act_set), .ac_in(ext_act_clr),
        .ack_fire(ack_fire), .ack_idx(pick_idx),
        .eoi_fire(eoi_fire), .eoi_idx(wr_data[IW-1:0]),
        .pend(pend_q), .act(act_q)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmask <= '0;
            bp0   <= '0;
            bp1   <= '0;
            gen0  <= 1'b0;
            gen1  <= 1'b0;
        end else if (wr_stb) begin
            unique case (kind)
                K_PMASK: pmask <= wr_data[7:0];
                K_BP0:   bp0   <= wr_data[2:0];
                K_BP1:   bp1   <= wr_data[2:0];
                K_GEN0:  gen0  <= wr_data[0];
                K_GEN1:  gen1  <= wr_data[0];
                default: ;
            endcase
        end
    end

    // read value and fault detection
    always_comb begin
        rd_next = '0;
        unique case (kind)
            K_PMASK: rd_next = DATA_W'(pmask);
            K_BP0:   rd_next = DATA_W'(bp0);
            K_BP1:   rd_next = DATA_W'(bp1);
            K_GEN0:  rd_next = DATA_W'(gen0);
            K_GEN1:  rd_next = DATA_W'(gen1);
            K_CTRL:  rd_next = CTRL_VALUE;
            K_ACK:   rd_next = pick_found ? DATA_W'(pick_idx) : DATA_W'(NONE_ID);
            default: rd_next = '0;
        endcase
    end

    always_comb begin
        err_next = 1'b0;
        if ((rd_stb || wr_stb) && kind == K_NONE) err_next = 1'b1;
        if (rd_stb && kind == K_EOI)              err_next = 1'b1;
        if (wr_stb && kind == K_ACK)              err_next = 1'b1;
        if (wr_stb && kind == K_EOI && eoi_bad)   err_next = 1'b1;
    end

    // response state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (rd_stb) st_nx = ST_DONE;
            ST_DONE: st_nx = rd_stb ? ST_DONE : ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            err     <= 1'b0;
        end else begin
            err <= err_next;
            if (rd_stb) rd_data <= rd_next;
        end
    end

    assign rd_valid = (st == ST_DONE);

    AST_ACK_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && reg_sel == 4'd6 && pend_q != '0 |=> rd_data < DATA_W'(N_IRQ) && act_q[rd_data[IW-1:0]]); // R1
    AST_ACK_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && reg_sel == 4'd6 && ext_pend_set == '0 && ext_pend_clr == '0 |=> pend_q == $past(pend_q)); // R1
    AST_ACK_EMPTY_ID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && reg_sel == 4'd6 && pend_q == '0 |=> rd_data == DATA_W'(NONE_ID)); // R2
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && reg_sel == 4'd7 && wr_data < DATA_W'(N_IRQ) |=> !act_q[$past(wr_data[IW-1:0])]); // R3
    AST_EOI_BAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && reg_sel == 4'd7 && wr_data >= DATA_W'(N_IRQ) |=> err); // R3
    AST_CTRL_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && reg_sel == 4'd5 |=> rd_data == CTRL_VALUE); // R7
    AST_UNIMPL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) && reg_sel[3] |=> err); // R8
    AST_RSP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid); // R9
    AST_RSP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid); // R9
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb)); // R9
endmodule

// File: tb/test_cpuif_top.sv
`timescale 1ns/1ps
module test_cpuif_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        rd_valid, err;
    logic [31:0] eps = '0, epc = '0, eas = '0, eac = '0;
    logic [31:0] pend_q, act_q;
    int compared = 0, mismatched = 0;
    logic [31:0] mpend = '0, mact = '0;

    always #4 clk = ~clk;

    cpuif_top i_cpuif_top (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .err(err),
        .ext_pend_set(eps), .ext_pend_clr(epc), .ext_act_set(eas), .ext_act_clr(eac),
        .pend_q(pend_q), .act_q(act_q)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 64'(i);
        return 64'd1023;
    endfunction

    // one access cycle; returns after the capturing edge, at the next falling edge
    task automatic cyc(input logic [3:0] s, input logic r, input logic w, input logic [63:0] d,
                       input logic [31:0] ps, input logic [31:0] pc,
                       input logic [31:0] as_, input logic [31:0] ac);
        logic [63:0] pk;
        pk = lowest(mpend);
        @(negedge clk);
        reg_sel = s; rd_stb = r; wr_stb = w; wr_data = d;
        eps = ps; epc = pc; eas = as_; eac = ac;
        @(negedge clk);
        rd_stb = 0; wr_stb = 0; eps = '0; epc = '0; eas = '0; eac = '0;
        // model in required order: external set, external clear, then operation
        mpend = (mpend | ps) & ~pc;
        mact  = (mact | as_) & ~ac;
        if (r && s == 4'd6 && pk != 64'd1023) mact[pk[4:0]] = 1'b1;
        if (w && s == 4'd7 && d < 64'd32) mact[d[4:0]] = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [63:0] v);
        cyc(s, 1, 0, '0, '0, '0, '0, '0);
        v = rd_data;
    endtask

    task automatic wr(input logic [3:0] s, input logic [63:0] d);
        cyc(s, 0, 1, d, '0, '0, '0, '0);
    endtask

    task automatic maps(input string req);
        chk(req, 64'(pend_q), 64'(mpend));
        chk(req, 64'(act_q), 64'(mact));
    endtask

    logic done = 1'b0;

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        chk("R11 rd_valid", 64'(rd_valid), 0);
        chk("R11 err", 64'(err), 0);
        maps("R11 maps");
        rst_n = 1'b1;
        for (int s = 0; s < 5; s++) begin
            rd(4'(s), v);
            chk("R11 cfg zero", v, 0);
        end

        // R9: valid for one cycle after a read, low afterwards
        rd(4'd0, v);
        chk("R9 valid", 64'(rd_valid), 1);
        @(negedge clk);
        chk("R9 drop", 64'(rd_valid), 0);

        // R4: priority mask sweep
        for (int m = 0; m < 256; m++) begin
            wr(4'd0, 64'hABCD_0000_0000_FF00 | 64'(m));
            rd(4'd0, v);
            chk("R4 pmask", v, 64'(m));
        end

        // R5: binary points independent
        for (int b = 0; b < 16; b++) begin
            wr(4'd1, 64'(b) | 64'hF0);
            wr(4'd2, 64'(b ^ 5));
            rd(4'd1, v);
            chk("R5 bp0", v, 64'(b & 7));
            rd(4'd2, v);
            chk("R5 bp1", v, 64'((b ^ 5) & 7));
        end

        // R6: enables take bit 0
        for (int e = 0; e < 4; e++) begin
            wr(4'd3, 64'(e) | 64'h10);
            wr(4'd4, 64'(~e & 3));
            rd(4'd3, v);
            chk("R6 gen0", v, 64'(e & 1));
            rd(4'd4, v);
            chk("R6 gen1", v, 64'((~e) & 1));
        end

        // R7: control constant, write ignored without error
        rd(4'd5, v);
        chk("R7 ctrl", v, 64'h440);
        wr(4'd5, '1);
        chk("R7 no err", 64'(err), 0);
        rd(4'd5, v);
        chk("R7 ctrl after write", v, 64'h440);

        // R8: unimplemented selects
        wr(4'd0, 64'h5A);
        for (int s = 8; s < 16; s++) begin
            wr(4'(s), '1);
            chk("R8 wr err", 64'(err), 1);
            rd(4'(s), v);
            chk("R8 rd zero", v, 0);
            chk("R8 rd err", 64'(err), 1);
        end
        rd(4'd0, v);
        chk("R8 pmask unchanged", v, 64'h5A);
        chk("R8 err cleared", 64'(err), 0);
        cyc(4'd6, 0, 1, 64'd3, '0, '0, '0, '0);
        chk("R8 ack write err", 64'(err), 1);
        maps("R8 ack write no effect");
        rd(4'd7, v);
        chk("R8 eoi read err", 64'(err), 1);
        chk("R8 eoi read zero", v, 0);

        // R2: nothing pending
        rd(4'd6, v);
        chk("R2 none id", v, 64'd1023);
        maps("R2 maps");

        // R1/R3: every single index
        for (int k = 0; k < 32; k++) begin
            cyc(4'd0, 0, 0, '0, 32'(1) << k, '0, '0, '0);
            rd(4'd6, v);
            chk("R1 ack id", v, 64'(k));
            chk("R1 valid", 64'(rd_valid), 1);
            maps("R1 maps");
            wr(4'd7, 64'(k));
            chk("R3 no err", 64'(err), 0);
            maps("R3 maps");
            cyc(4'd0, 0, 0, '0, '0, 32'(1) << k, '0, '0);
        end

        // R1: multi-bit pattern, repeated acknowledge keeps lowest
        cyc(4'd0, 0, 0, '0, 32'h8001_0100, '0, '0, '0);
        rd(4'd6, v);
        chk("R1 multi first", v, 64'd8);
        rd(4'd6, v);
        chk("R1 multi repeat", v, 64'd8);
        maps("R1 multi maps");
        cyc(4'd0, 0, 0, '0, '0, 32'h0000_0100, '0, '0);
        rd(4'd6, v);
        chk("R1 multi next", v, 64'd16);
        cyc(4'd0, 0, 0, '0, '0, 32'h0001_0000, '0, '0);
        rd(4'd6, v);
        chk("R1 multi top", v, 64'd31);
        maps("R1 multi maps end");

        // R3: illegal completion ID
        cyc(4'd7, 0, 1, 64'd32, '0, '0, '0, '0);
        chk("R3 bad id err", 64'(err), 1);
        maps("R3 bad id maps");
        cyc(4'd7, 0, 1, 64'h1_0000_0001, '0, '0, '0, '0);
        chk("R3 big id err", 64'(err), 1);
        maps("R3 big id maps");
        cyc(4'd0, 0, 0, '0, '0, '1, '0, '1);
        maps("R10 clear all");

        // R10: ordering
        cyc(4'd6, 1, 0, '0, 32'h8, '0, '0, '0);
        chk("R10 ack uses old pend", rd_data, 64'd1023);
        maps("R10 pend set same cycle");
        cyc(4'd6, 1, 0, '0, '0, '0, '0, 32'h8);
        chk("R10 ack over ext clr id", rd_data, 64'd3);
        chk("R10 ack over ext clr", 64'(act_q[3]), 1);
        maps("R10 maps a");
        cyc(4'd7, 0, 1, 64'd3, '0, '0, 32'h8, '0);
        chk("R10 eoi over ext set", 64'(act_q[3]), 0);
        maps("R10 maps b");
        cyc(4'd0, 0, 0, '0, 32'h4, 32'h4, 32'h2, 32'h2);
        maps("R10 clear beats set");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule